// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of one DMA channel. A peripheral raises a request. The sequencer then asks the host for the bus with a hold request. Once the host grants the bus, the sequencer acknowledges the peripheral and runs transfers. Each transfer holds the acknowledge for a fixed number of clock cycles and presents the current address. After each transfer, the current address steps up or down by one and the current word count steps down by one.

A small write port programs three things: a base address, a base word count and a mode register. Writing a base register also loads the matching current register. The mode register selects one of four service styles: single, block, demand and cascade. It also holds the address direction and the auto-initialization enable. Writing the mode register clears the channel mask.

A service ends in one of two ways: the word count rolls over from zero to all ones, or an external end-of-process input is seen. At that point the channel either reloads its current registers from the base registers or masks itself. In cascade mode the channel only relays the request and grant handshake for a downstream controller.

Top module: `dmaseq_channel`

## Requirements
- R1: When the channel is idle and unmasked, a request sampled high raises the hold request on the next cycle. The acknowledge and address-valid outputs rise only in the cycle after the grant is sampled high.
- R2: Each transfer decrements the current word count by one. It steps the current address by +1 when mode bit 2 is 0 and by -1 when mode bit 2 is 1, so the logged addresses run base, base±1, base±2 and so on.
- R3: Terminal count occurs on the transfer that starts with a current count of zero. A programmed count N therefore gives N+1 transfers, and the end-of-process output pulses during the last cycle of the final transfer.
- R4: Single mode (mode bits [1:0] = 1) makes one transfer per grant. It then drops the hold request even when the request stays high, so each transfer needs a fresh hold/grant handshake.
- R5: Block mode (mode bits [1:0] = 2) keeps the bus from the first transfer to end-of-process under one grant. The request only needs to stay high until the acknowledge appears.
- R6: Demand mode (mode bits [1:0] = 0) continues while the request is high. If the request is low at the end of a transfer, the bus is released, the current address and count are kept, and a later request resumes from them.
- R7: An external end-of-process input that is high in the last cycle of a transfer ends the service after that transfer and pulses the end-of-process output.
- R8: With auto-init (mode bit 3 = 1), end-of-process reloads the current address and count from the base registers and leaves the channel enabled. Without auto-init the channel masks itself and ignores requests until the mode register is written. The channel also comes out of reset masked.
- R9: Cascade mode (mode bits [1:0] = 3) raises the hold request while the request is high. It mirrors the grant onto the acknowledge, never asserts address-valid, and drops the hold request once the request goes low.
- R10: Write select 0 loads the base and current address, and select 1 loads the base and current count. Select 2 loads the mode register and clears the mask, leaving the current address and count untouched.
- R11: Every transfer holds the acknowledge and address-valid for exactly XFER_CYC consecutive cycles (2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 count, 2 mode |
| wr_data | input | DW | Write data |
| dreq | input | 1 | Peripheral request |
| hlda | input | 1 | Bus grant from host |
| eop_in | input | 1 | External end-of-process |
| hrq | output | 1 | Hold request to host |
| dack | output | 1 | Acknowledge to peripheral |
| addr_vld | output | 1 | Address bus is driven for a transfer |
| addr | output | AW | Current transfer address (zero when not valid) |
| eop_out | output | 1 | End-of-process pulse on the final transfer |

## Verification
On every cycle the assertions check several behaviours. They check the one-cycle rise of the hold request from idle and that a transfer starts only after a grant. They check the per-transfer step of address and count, the end-of-process pulse whenever a transfer starts at count zero, the bus release after each single-mode transfer, the mask and reload on end-of-process, and that address-valid stays low in cascade mode. Other behaviours involve a whole service and only the bench's scenarios can show them. These are the full address sequence, the number of grants per service in each mode, and the resumption of a paused demand service. They also include the resume after an external end-of-process and the requests ignored by a masked channel.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    MD_DEMAND  = 2'd0,
    MD_SINGLE  = 2'd1,
    MD_BLOCK   = 2'd2,
    MD_CASCADE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_XFER = 2'd2,
    S_CAS  = 2'd3
  } seq_state_e;

  // mode register layout: [3] auto-init, [2] decrement, [1:0] mode
  typedef struct packed {
    logic       autoinit;
    logic       dec;
    xfer_mode_e mode;
  } mode_reg_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

endpackage

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
  import dmaseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          xfer_done,
  input  logic          eop_now,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic [AW-1:0] base_addr,
  output logic [CW-1:0] base_cnt,
  output mode_reg_t     mode_q,
  output logic          masked,
  output logic          tc_now
);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic dec);
    return dec ? a - AW'(1) : a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] step_cnt(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  assign tc_now = (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
      mode_q    <= '0;
      masked    <= 1'b1;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ADDR: begin
          base_addr <= wr_data[AW-1:0];
          cur_addr  <= wr_data[AW-1:0];
        end
        SEL_CNT: begin
          base_cnt <= wr_data[CW-1:0];
          cur_cnt  <= wr_data[CW-1:0];
        end
        SEL_MODE: begin
          mode_q <= mode_reg_t'(wr_data[3:0]);
          masked <= 1'b0;
        end
        default: ;
      endcase
    end else if (xfer_done) begin
      if (eop_now && mode_q.autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= step_addr(cur_addr, mode_q.dec);
        cur_cnt  <= step_cnt(cur_cnt);
        if (eop_now) masked <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
  import dmaseq_pkg::*;
#(
  parameter int XFER_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dreq,
  input  logic       hlda,
  input  logic       eop_in,
  input  xfer_mode_e mode,
  input  logic       masked,
  input  logic       tc_now,
  output logic       hrq,
  output logic       dack,
  output logic       addr_vld,
  output logic       xfer_done,
  output logic       eop_now,
  output logic       st_idle
);

  localparam int CYW = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;

  seq_state_e st, st_n;
  logic [CYW-1:0] cyc;
  logic last_cyc;

  assign last_cyc  = (cyc == CYW'(XFER_CYC - 1));
  assign xfer_done = (st == S_XFER) && last_cyc;
  assign eop_now   = xfer_done && (tc_now || eop_in);
  assign st_idle   = (st == S_IDLE);
  assign hrq       = (st != S_IDLE);
  assign addr_vld  = (st == S_XFER);
  assign dack      = (st == S_XFER) || ((st == S_CAS) && hlda);

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (dreq && !masked) st_n = (mode == MD_CASCADE) ? S_CAS : S_REQ;
      S_REQ:  if (hlda) st_n = S_XFER;
      S_XFER: if (xfer_done) begin
        if (eop_now) st_n = S_IDLE;
        else begin
          case (mode)
            MD_BLOCK:  st_n = S_XFER;
            MD_DEMAND: st_n = dreq ? S_XFER : S_IDLE;
            default:   st_n = S_IDLE;
          endcase
        end
      end
      S_CAS:  if (!dreq) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cyc <= '0;
    end else begin
      st <= st_n;
      if (st == S_XFER && !last_cyc) cyc <= cyc + CYW'(1);
      else                           cyc <= '0;
    end
  end

endmodule

// File: rtl/dmaseq_channel.sv
module dmaseq_channel
  import dmaseq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int DW       = 16,
  parameter int XFER_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          dreq,
  input  logic          hlda,
  input  logic          eop_in,
  output logic          hrq,
  output logic          dack,
  output logic          addr_vld,
  output logic [AW-1:0] addr,
  output logic          eop_out
);

  logic [AW-1:0] cur_addr, base_addr;
  logic [CW-1:0] cur_cnt, base_cnt;
  mode_reg_t     mode_q;
  logic          masked, tc_now, xfer_done, st_idle;

  dmaseq_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_done(xfer_done), .eop_now(eop_out),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .base_addr(base_addr), .base_cnt(base_cnt),
    .mode_q(mode_q), .masked(masked), .tc_now(tc_now)
  );

  dmaseq_fsm #(.XFER_CYC(XFER_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .hlda(hlda), .eop_in(eop_in),
    .mode(mode_q.mode), .masked(masked), .tc_now(tc_now),
    .hrq(hrq), .dack(dack), .addr_vld(addr_vld), .xfer_done(xfer_done),
    .eop_now(eop_out), .st_idle(st_idle)
  );

  assign addr = addr_vld ? cur_addr : '0;

endmodule

// File: rtl/dmaseq_channel_chk.sv
module dmaseq_channel_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          dreq,
  input logic          hlda,
  input logic          hrq,
  input logic          addr_vld,
  input logic          eop_out,
  input logic          xfer_done,
  input logic          st_idle,
  input logic          masked,
  input logic [3:0]    mode_bits,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_cnt,
  input logic [CW-1:0] base_cnt
);

  a_r1_req_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && dreq && !masked) |=> hrq);

  a_r1_xfer_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_vld) |-> $past(hlda));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !eop_out && !wr_en) |=> (cur_cnt == $past(cur_cnt) - CW'(1)));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !eop_out && !wr_en) |=>
      (cur_addr == ($past(mode_bits[2]) ? $past(cur_addr) - AW'(1) : $past(cur_addr) + AW'(1))));

  a_r3_tc_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && cur_cnt == '0) |-> eop_out);

  a_r4_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && mode_bits[1:0] == 2'd1) |=> !hrq);

  a_r8_mask_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_out && !mode_bits[3] && !wr_en) |=> masked);

  a_r8_autoinit_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_out && mode_bits[3] && !wr_en) |=> (cur_cnt == $past(base_cnt) && !masked));

  a_r9_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[1:0] == 2'd3 && $stable(mode_bits)) |-> !addr_vld);

endmodule

bind dmaseq_channel dmaseq_channel_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dreq(dreq), .hlda(hlda), .hrq(hrq),
  .addr_vld(addr_vld), .eop_out(eop_out), .xfer_done(xfer_done), .st_idle(st_idle),
  .masked(masked), .mode_bits(mode_q), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
  .base_cnt(base_cnt)
);

// File: tb/dmaseq_channel_test.sv
`timescale 1ns/100ps
module dmaseq_channel_test;

  localparam int XC = 2;
  localparam logic [1:0] M_DEM = 2'd0, M_SGL = 2'd1, M_BLK = 2'd2, M_CAS = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic dreq = 1'b0, hlda = 1'b0, eop_in = 1'b0;
  logic hrq, dack, addr_vld, eop_out;
  logic [15:0] addr;

  int total = 0, bad = 0;
  int dk = 0, nlog = 0, grants = 0, eop_at = -1;
  logic prev_hrq = 1'b0;
  logic [15:0] alog [0:63];

  dmaseq_channel #(.AW(16), .CW(16), .DW(16), .XFER_CYC(XC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dreq(dreq), .hlda(hlda), .eop_in(eop_in), .hrq(hrq), .dack(dack),
    .addr_vld(addr_vld), .addr(addr), .eop_out(eop_out)
  );

  always #2.5 clk = ~clk;

  // host model: grant follows the hold request one cycle later
  always @(posedge clk) begin
    #1 hlda = hrq;
  end

  always @(negedge clk) begin
    if (hrq && !prev_hrq) grants++;
    prev_hrq = hrq;
    if (dack && addr_vld) begin
      if (dk % XC == 0 && nlog < 64) begin
        alog[nlog] = addr;
        nlog++;
      end
      if (eop_out) eop_at = dk / XC;
      dk++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mon_clr();
    dk = 0; nlog = 0; grants = 0; eop_at = -1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic check_addrs(input logic [15:0] base, input bit dec, input int n, input string tag);
    int bad_i = -1;
    for (int i = 0; i < n; i++) begin
      logic [15:0] e = dec ? base - 16'(i) : base + 16'(i);
      if (bad_i < 0 && alog[i] != e) bad_i = i;
    end
    if (bad_i < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, alog[bad_i], dec ? base - 16'(bad_i) : base + 16'(bad_i));
  endtask

  task automatic run(input bit prog, input logic [1:0] md, input bit dec, input bit ai,
                     input logic [15:0] base, input int cnt, input string tag);
    if (prog) begin
      wr(2'd0, base);
      wr(2'd1, 16'(cnt));
    end
    wr(2'd2, {12'd0, ai, dec, md});
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    if (md == M_BLK) begin
      wait (dk > 0);
      @(posedge clk); #1 dreq = 1'b0;   // R5: request only until acknowledge
    end
    for (int i = 0; i < 400 && eop_at < 0; i++) @(posedge clk);
    #1 dreq = 1'b0;
    repeat (4) @(posedge clk);
    check(eop_at == cnt, {tag, " R3 eop on last transfer"}, eop_at, cnt);
    check(nlog == cnt + 1, {tag, " R3 transfer count"}, nlog, cnt + 1);
    check(dk == (cnt + 1) * XC, {tag, " R11 acknowledge cycles"}, dk, (cnt + 1) * XC);
    check_addrs(base, dec, cnt + 1, {tag, " R2 address sequence"});
    if (md == M_SGL) check(grants == cnt + 1, {tag, " R4 one grant per transfer"}, grants, cnt + 1);
    else if (md == M_BLK) check(grants == 1, {tag, " R5 single grant"}, grants, 1);
    else check(grants == 1, {tag, " R6 single grant with request held"}, grants, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!hrq && !dack && !addr_vld && !eop_out, "reset outputs idle (R8)", {hrq, dack, addr_vld, eop_out}, 0);

    // R8: masked out of reset
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    repeat (10) @(posedge clk);
    #1 dreq = 1'b0;
    check(grants == 0, "R8 masked after reset ignores request", grants, 0);

    // sweep: modes x direction x count
    for (int m = 0; m < 3; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 4; c++) begin
          logic [1:0] md = (m == 0) ? M_SGL : (m == 1) ? M_BLK : M_DEM;
          run(1'b1, md, d[0], 1'b0, 16'h0080, c, $sformatf("sweep m%0d d%0d c%0d", md, d, c));
        end
      end
    end

    // R8: after non-auto-init end, requests ignored
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    repeat (20) @(posedge clk);
    #1 dreq = 1'b0;
    check(grants == 0 && dk == 0, "R8 masked after end-of-process", grants, 0);

    // R8: auto-init reload and stay enabled
    run(1'b1, M_BLK, 1'b1, 1'b1, 16'h0200, 2, "autoinit first");
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    wait (dk > 0);
    @(posedge clk); #1 dreq = 1'b0;
    for (int i = 0; i < 100 && eop_at < 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    check(nlog == 3 && eop_at == 2, "R8 auto-init service repeats", nlog, 3);
    check_addrs(16'h0200, 1'b1, 3, "R8 auto-init reloaded address");

    // R1 + R6: demand pause and resume
    wr(2'd0, 16'h0300);
    wr(2'd1, 16'd5);
    wr(2'd2, {12'd0, 1'b0, 1'b0, M_DEM});
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    @(negedge clk);
    check(!hrq, "R1 no hold request in request cycle", hrq, 0);
    @(negedge clk);
    check(hrq && !dack, "R1 hold request next cycle, no acknowledge before grant", {hrq, dack}, 2);
    @(negedge clk);
    check(dack && addr_vld, "R1 acknowledge after grant", {dack, addr_vld}, 3);
    wait (dk == 2 * XC - 1);
    @(posedge clk); #1 dreq = 1'b0;
    repeat (6) @(posedge clk);
    check(nlog == 2 && !hrq && eop_at < 0, "R6 demand releases when request drops", nlog, 2);
    run(1'b0, M_DEM, 1'b0, 1'b0, 16'h0302, 3, "R6 demand resume");

    // R7 + R10: external end-of-process, then resume by mode write only
    wr(2'd0, 16'h0400);
    wr(2'd1, 16'd9);
    wr(2'd2, {12'd0, 1'b0, 1'b0, M_BLK});
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    wait (dk == 3 * XC - 1);
    @(posedge clk); #1 eop_in = 1'b1; dreq = 1'b0;
    @(posedge clk); #1 eop_in = 1'b0;
    repeat (4) @(posedge clk);
    check(nlog == 3 && eop_at == 2 && !hrq, "R7 external end stops after transfer", nlog, 3);
    run(1'b0, M_BLK, 1'b0, 1'b0, 16'h0403, 6, "R10 mode write keeps current");

    // R9: cascade relay
    wr(2'd2, {12'd0, 1'b0, 1'b0, M_CAS});
    mon_clr();
    @(posedge clk); #1 dreq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(hrq, "R9 cascade raises hold request", hrq, 1);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(dack && !addr_vld && addr == 16'h0, "R9 cascade relays grant, no address", {dack, addr_vld}, 2);
      @(negedge clk);
    end
    @(posedge clk); #1 dreq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!hrq && !dack, "R9 cascade drops with request", {hrq, dack}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule